// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is a small performance monitor for a processor core. It holds six 32-bit event counters and two 64-bit control words, all reached through one register port with a single-cycle write and a combinational read. Each counter counts either core clock cycles or retired instructions. A pulse on the retire input marks one retired instruction.

The first control word holds the freeze controls. A global freeze bit stops every counter. One group freeze bit covers counters 1 to 4, and a second group freeze bit covers counters 5 and 6. The first control word also holds a two-bit control field that the block stores and does not act on.

The second control word holds an 8-bit event selector for each of counters 1 to 4. Counters 5 and 6 ignore the selectors: counter 5 counts instructions and counter 6 counts cycles.

The expected use has three steps:
1. Freeze the counters.
2. Program the selectors and preload the counters.
3. Unfreeze the counters.

Counters can also be read and rewritten while they run.

Top module: `pmon_unit`

## Requirements
- R1: After reset, control word 0 reads 0x0000_0000_8000_0000, so the global freeze bit (bit 31) is set. Control word 1 and all six counters read zero. No counter advances until software clears bit 31.
- R2: While control word 0 bit 31 is set, no counter advances. While it is clear, counting is governed by the group freeze bits and the event decode.
- R3: Control word 0 bit 5 freezes counters 1 to 4, and bit 4 freezes counters 5 and 6. A counter advances only when both bit 31 and its group bit are clear.
- R4: In control word 1, bits 31:24, 23:16, 15:8 and 7:0 are the selectors of counters 1, 2, 3 and 4. On any of these counters, selector 0x02 counts instructions and selector 0x1E counts cycles.
- R5: Selector 0xF0 counts cycles and selector 0xFE counts instructions, but only on counter 1. On counters 2 to 4 these two codes are invalid.
- R6: Counter 5 always counts instructions and counter 6 always counts cycles, whatever control word 1 holds.
- R7: A counter whose selector is not one of the codes listed above holds its value.
- R8: Both control words store all 64 written bits and read them back unchanged. This includes the two-bit field in bits 19:18 of control word 0.
- R9: A control-word write takes effect on the next clock. The counting in the clock of the write still uses the old configuration.
- R10: A write to a counter replaces its value. When a write and an increment hit the same counter in one clock, the written value is kept.
- R11: A cycle counter adds one on every active clock. An instruction counter adds one on each active clock in which the retire input is high. Counters wrap modulo 2^32.
- R12: Addresses 0 to 5 read counters 1 to 6, zero-extended to 64 bits. Address 6 reads control word 0 and address 7 reads control word 1. Reads return the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the cycle event |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | High for one clock per retired instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0-5 counters, 6/7 control words) |
| wr_data_i | input | 64 | Write data; counters take the low 32 bits |
| rd_addr_i | input | 3 | Read address, same map as writes |
| rd_data_o | output | 64 | Combinational read data |

## Verification
The bench runs a behavioural reference model and compares all eight registers after every clock.

The retire input is driven with an irregular pseudo-random pattern. This pattern separates instruction counters from cycle counters and shows whether a counter is missing pulses.

The selectors are set to every listed code on every programmable counter, and also to unlisted codes. This shows whether the counter-1-only codes leak onto counters 2 to 4.

Freeze combinations are applied in the same clock as counting. This shows whether group gating and the one-clock delay of configuration writes are respected.

Counter writes are made while the counter is incrementing, and counters are preloaded near 2^32. These cases test whether a write takes priority over an increment and whether counters wrap correctly.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

   // Event kind a counter is bound to for the current clock
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_CYC  = 2'd1,
      EV_INS  = 2'd2
   } pmon_event_e;

endpackage

// File: rtl/pmon_ctl_regs.sv
module pmon_ctl_regs #(
   parameter int unsigned          CTL_W  = 64,
   parameter int unsigned          AW     = 3,
   parameter int unsigned          ADDR0  = 6,
   parameter int unsigned          ADDR1  = 7,
   parameter logic [CTL_W-1:0]     RST0   = '0,
   parameter logic [CTL_W-1:0]     RST1   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] ctl0_q,
   output logic [CTL_W-1:0] ctl1_q
);

   localparam logic [AW-1:0] A0 = AW'(ADDR0);
   localparam logic [AW-1:0] A1 = AW'(ADDR1);

   if (ADDR0 == ADDR1) begin : g_addr_clash
      $error("pmon_ctl_regs: control words share an address");
   end

   logic hit0, hit1;
   assign hit0 = wr_en && (wr_addr == A0);
   assign hit1 = wr_en && (wr_addr == A1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl0_q <= RST0;
         ctl1_q <= RST1;
      end else begin
         if (hit0) ctl0_q <= wr_data;
         if (hit1) ctl1_q <= wr_data;
      end
   end

   // R8
   ctl0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit0 |=> ctl0_q == $past(wr_data));

   // R9
   ctl1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit1 |=> $stable(ctl1_q));

endmodule

// File: rtl/pmon_sel_decode.sv
module pmon_sel_decode
   import pmon_pkg::*;
#(
   parameter int unsigned     IDX      = 0,
   parameter int unsigned     NPROG    = 4,
   parameter int unsigned     SEL_W    = 8,
   parameter logic [SEL_W-1:0] C_INS   = 8'h02,
   parameter logic [SEL_W-1:0] C_CYC   = 8'h1E,
   parameter logic [SEL_W-1:0] C_CYC1  = 8'hF0,
   parameter logic [SEL_W-1:0] C_INS1  = 8'hFE
) (
   input  logic [SEL_W-1:0] sel,
   output pmon_event_e      ev
);

   localparam bit IS_FIXED = (IDX >= NPROG);
   localparam bit IS_FIRST = (IDX == 0);

   if (IS_FIXED) begin : g_fixed
      // Fixed counters alternate instruction, cycle, ...
      localparam bit FIX_CYC = ((IDX - NPROG) % 2) == 1;
      assign ev = FIX_CYC ? EV_CYC : EV_INS;
   end else if (IS_FIRST) begin : g_first
      always_comb begin
         unique case (sel)
            C_INS, C_INS1: ev = EV_INS;
            C_CYC, C_CYC1: ev = EV_CYC;
            default:       ev = EV_NONE;
         endcase
      end
   end else begin : g_other
      always_comb begin
         unique case (sel)
            C_INS:   ev = EV_INS;
            C_CYC:   ev = EV_CYC;
            default: ev = EV_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
   import pmon_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  pmon_event_e      ev,
   input  logic             retire,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt_q
);

   logic step;

   always_comb begin
      unique case (ev)
         EV_CYC:  step = active;
         EV_INS:  step = active && retire;
         default: step = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (wr_hit)  cnt_q <= wr_val;
      else if (step)    cnt_q <= cnt_q + CNT_W'(1);
   end

   // R10
   wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> cnt_q == $past(wr_val));

   // R2
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !active) |=> $stable(cnt_q));

   // R7
   invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && ev == EV_NONE) |=> $stable(cnt_q));

   // R11
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1));

   // R11
   ins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && ev == EV_INS && !retire) |=> $stable(cnt_q));

endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
   import pmon_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned CTL_W    = 64,
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned NPROG    = 4,
   parameter int unsigned NFIX     = 2,
   parameter int unsigned FRZ_BIT  = 31,
   parameter int unsigned GRPA_BIT = 5,
   parameter int unsigned GRPB_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [63:0]      wr_data_i,
   input  logic [2:0]       rd_addr_i,
   output logic [63:0]      rd_data_o
);

   localparam int unsigned NCNT  = NPROG + NFIX;
   localparam int unsigned AW    = 3;
   localparam int unsigned A_C0  = NCNT;
   localparam int unsigned A_C1  = NCNT + 1;
   localparam logic [CTL_W-1:0] RST0 = CTL_W'(1) << FRZ_BIT;

   if (NCNT + 2 > (1 << AW)) begin : g_chk_addr
      $error("pmon_unit: register map exceeds address width");
   end
   if (SEL_W * NPROG > CTL_W) begin : g_chk_sel
      $error("pmon_unit: selectors do not fit in a control word");
   end
   if (CNT_W > CTL_W || CTL_W != 64) begin : g_chk_w
      $error("pmon_unit: counter or control width unsupported");
   end
   if (FRZ_BIT >= CTL_W || GRPA_BIT >= CTL_W || GRPB_BIT >= CTL_W) begin : g_chk_bits
      $error("pmon_unit: freeze bit outside control word");
   end

   logic [CTL_W-1:0] ctl0_q, ctl1_q;
   logic [CNT_W-1:0] cnt_q [NCNT];

   pmon_ctl_regs #(
      .CTL_W (CTL_W),
      .AW    (AW),
      .ADDR0 (A_C0),
      .ADDR1 (A_C1),
      .RST0  (RST0),
      .RST1  ('0)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .wr_data (wr_data_i),
      .ctl0_q  (ctl0_q),
      .ctl1_q  (ctl1_q)
   );

   for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      localparam int unsigned GRP_BIT = (k < NPROG) ? GRPA_BIT : GRPB_BIT;
      localparam int unsigned SEL_LO  = (k < NPROG) ? (NPROG - 1 - k) * SEL_W : 0;

      logic [SEL_W-1:0] sel;
      pmon_event_e      ev;
      logic             active;
      logic             wr_hit;

      assign sel    = ctl1_q[SEL_LO +: SEL_W];
      assign active = !ctl0_q[FRZ_BIT] && !ctl0_q[GRP_BIT];
      assign wr_hit = wr_en_i && (wr_addr_i == AW'(k));

      pmon_sel_decode #(
         .IDX   (k),
         .NPROG (NPROG),
         .SEL_W (SEL_W)
      ) u_dec (
         .sel (sel),
         .ev  (ev)
      );

      pmon_counter #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (active),
         .ev     (ev),
         .retire (retire_i),
         .wr_hit (wr_hit),
         .wr_val (wr_data_i[CNT_W-1:0]),
         .cnt_q  (cnt_q[k])
      );
   end

   // Read mux: live counter values, then control words
   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NCNT; k++) begin
         if (rd_addr_i == AW'(k)) rd_data_o = CTL_W'(cnt_q[k]);
      end
      if (rd_addr_i == AW'(A_C0)) rd_data_o = ctl0_q;
      if (rd_addr_i == AW'(A_C1)) rd_data_o = ctl1_q;
   end

   // R1
   frz_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl0_q[FRZ_BIT] && !wr_en_i) |=> $stable(cnt_q[0]) && $stable(cnt_q[NCNT-1]));

   // R3
   grpb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl0_q[GRPB_BIT] && !wr_en_i) |=> $stable(cnt_q[NPROG]));

   // R6
   fix_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl0_q[FRZ_BIT] && !ctl0_q[GRPB_BIT] && !wr_en_i)
         |=> cnt_q[NCNT-1] == $past(cnt_q[NCNT-1]) + CNT_W'(1));

endmodule

// File: tb/tb_pmon_unit.sv
`timescale 1ns/1ps
module tb_pmon_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  wr_addr_i = '0;
   logic [63:0] wr_data_i = '0;
   logic [2:0]  rd_addr_i = '0;
   logic [63:0] rd_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference model state
   logic [31:0] m_cnt [6];
   logic [63:0] m_c0, m_c1;
   logic [31:0] lfsr = 32'hACE1_2345;

   always #4 clk = ~clk;

   pmon_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire_i  (retire_i),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   // 0 none, 1 cycles, 2 instructions
   function automatic int m_ev(int k, logic [63:0] c1);
      logic [7:0] s;
      if (k == 4) return 2;
      if (k == 5) return 1;
      s = c1[(3 - k) * 8 +: 8];
      case (s)
         8'h02: return 2;
         8'h1E: return 1;
         8'hF0: return (k == 0) ? 1 : 0;
         8'hFE: return (k == 0) ? 2 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] m_read(int a);
      if (a < 6) return {32'h0, m_cnt[a]};
      if (a == 6) return m_c0;
      return m_c1;
   endfunction

   task automatic m_reset();
      for (int k = 0; k < 6; k++) m_cnt[k] = '0;
      m_c0 = 64'h0000_0000_8000_0000;
      m_c1 = '0;
   endtask

   task automatic m_clock();
      logic [31:0] nxt [6];
      for (int k = 0; k < 6; k++) begin
         int e;
         logic act;
         e = m_ev(k, m_c1);
         act = !m_c0[31] && !((k < 4) ? m_c0[5] : m_c0[4]);
         nxt[k] = m_cnt[k];
         if (act && (e == 1 || (e == 2 && retire_i))) nxt[k] = m_cnt[k] + 32'd1;
         if (wr_en_i && wr_addr_i == 3'(k)) nxt[k] = wr_data_i[31:0];
      end
      for (int k = 0; k < 6; k++) m_cnt[k] = nxt[k];
      if (wr_en_i && wr_addr_i == 3'd6) m_c0 = wr_data_i;
      if (wr_en_i && wr_addr_i == 3'd7) m_c1 = wr_data_i;
   endtask

   task automatic peek(int a, logic [63:0] exp, string req);
      rd_addr_i = 3'(a);
      #0.2;
      checks++;
      if (rd_data_o !== exp) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data_o, exp);
      end
   endtask

   task automatic compare_all();
      for (int a = 0; a < 8; a++) peek(a, m_read(a), cur_req);
   endtask

   // one clock with given stimulus, model update, compare after the edge
   task automatic step(bit we, int wa, logic [63:0] wd, bit ret);
      wr_en_i   = we;
      wr_addr_i = 3'(wa);
      wr_data_i = wd;
      retire_i  = ret;
      @(posedge clk);
      m_clock();
      @(negedge clk);
      wr_en_i = 1'b0;
      compare_all();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(1'b0, 0, '0, lfsr[3] ^ lfsr[17]);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1: reset values
      peek(6, 64'h0000_0000_8000_0000, "R1");
      peek(7, 64'h0, "R1");
      peek(5, 64'h0, "R1");
      cur_req = "R1";
      run(6);

      // R4 R5: selectors 02, 1E, F0 (invalid on 3), FE (invalid on 4)
      cur_req = "R4";
      step(1'b1, 7, 64'h0000_0000_021E_F0FE, 1'b1);
      // R9: unfreeze; clock of write still frozen
      cur_req = "R9";
      step(1'b1, 6, 64'h0, 1'b1);
      cur_req = "R2";
      run(20);

      // R3: freeze group 1-4, then 5-6
      cur_req = "R3";
      step(1'b1, 6, 64'h20, 1'b1);
      run(8);
      step(1'b1, 6, 64'h10, 1'b1);
      run(8);
      step(1'b1, 6, 64'h0, 1'b0);

      // R5: counter 1 on F0 then FE; FE/F0 on others stay invalid
      cur_req = "R5";
      step(1'b1, 7, 64'h0000_0000_F0FE_F01E, 1'b0);
      run(10);
      step(1'b1, 7, 64'h0000_0000_FEF0_FE02, 1'b1);
      run(10);

      // R7 R6: unlisted codes; counters 5 and 6 keep going
      cur_req = "R7";
      step(1'b1, 7, 64'hFFFF_FFFF_5500_1F03, 1'b1);
      run(10);
      cur_req = "R6";
      step(1'b1, 7, 64'h0, 1'b1);
      run(10);

      // R10: write collides with increment on a running counter
      cur_req = "R10";
      step(1'b1, 7, 64'h0000_0000_1E1E_0202, 1'b1);
      step(1'b1, 5, 64'hAAAA_AAAA_1234_0000, 1'b1);
      step(1'b1, 0, 64'h0000_0000_0000_0100, 1'b0);
      run(5);

      // R11: wrap of cycle and instruction counters
      cur_req = "R11";
      step(1'b1, 5, 64'hFFFF_FFFD, 1'b0);
      step(1'b1, 4, 64'hFFFF_FFFF, 1'b0);
      step(1'b0, 0, '0, 1'b1);
      run(4);
      peek(5, {32'h0, m_cnt[5]}, "R11");

      // R12: live reads while running
      cur_req = "R12";
      run(10);

      // R8: full readback with counter-control field, all frozen
      cur_req = "R8";
      step(1'b1, 6, 64'h1234_5678_800C_0030, 1'b1);
      peek(6, 64'h1234_5678_800C_0030, "R8");
      step(1'b1, 7, 64'hDEAD_BEEF_CAFE_F00D, 1'b1);
      peek(7, 64'hDEAD_BEEF_CAFE_F00D, "R8");
      run(6);

      finish_run();
   end

endmodule